// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Updates

This block is a 32-pin general-purpose I/O port controlled over a simple 32-bit register bus with word indices. Software holds a driven-value register and a direction register. The pad inputs pass through a two-flop synchronizer, and the synchronized value can be read back. Three write-only alias registers change selected output bits in one bus write each: one sets bits, one clears bits and one inverts bits. Independent agents can therefore change their own pins without a read-modify-write sequence and without disturbing pins they do not own.

The readable pin-level register is direction-aware. For a pin configured as an output, the value read is the level the port is driving. For a pin configured as an input, the value read is the synchronized pad value. Register reads are captured on the clock edge that accepts them, and the result then stays on the read-data port until the next read. Pin muxing, pulls, drive strength, interrupts and bus error responses are outside this block.

Top module: `gpio_port32`

## Requirements
- R1: After reset, `pad_out` and `pad_oe` are all zero, and the driven-value register (index 0) and the direction register (index 5) both read as zero.
- R2: A write to index 0 loads all 32 bits of the driven-value register. `pad_out` shows the new value after the accepting edge, and a read of index 0 returns it.
- R3: A write to index 1 (set alias) makes every driven-value bit whose written bit is 1 equal to 1 and leaves every other bit unchanged.
- R4: A write to index 2 (clear alias) makes every driven-value bit whose written bit is 1 equal to 0 and leaves every other bit unchanged.
- R5: A write to index 3 (toggle alias) inverts every driven-value bit whose written bit is 1 and leaves every other bit unchanged.
- R6: A write to index 5 loads the direction register. `pad_oe` equals it (1 = output, 0 = input), and a read of index 5 returns it.
- R7: A read of index 4 returns, for each bit, the driven-value bit when the direction bit is 1 and the synchronized pad bit when it is 0. Index 4 is read-only: a write to it changes neither `pad_out`, `pad_oe` nor later reads.
- R8: Reads of indices 1, 2 and 3, and of any index from 6 to 15, return zero.
- R9: A `pad_in` change applied before clock edge k is not returned by reads accepted at edges k or k+1. It is returned by a read accepted at edge k+2.
- R10: Alias writes on consecutive cycles are each applied in order. `pad_out` after each accepting edge reflects every write accepted up to that edge.
- R11: A read is captured into `bus_rdata` at the edge that accepts it. `bus_rdata` holds that value through idle cycles and writes until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Driven pad values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The alias writes are applied to a driven value that holds a mix of ones and zeros. This shows that set, clear and toggle touch only the selected bits, and a set with an all-zero mask shows that zero bits have no effect. The pin-level read is tried with a direction mask that splits the port into output and input halves while `pad_in` differs from the driven value, so each half must come from its own source. A pad change issued together with a read measures the synchronizer depth edge by edge. Set, clear and toggle writes on three consecutive cycles show that no update is lost or reordered.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_DOUT = 4'd0,
    IDX_SET  = 4'd1,
    IDX_CLR  = 4'd2,
    IDX_TGL  = 4'd3,
    IDX_DIN  = 4'd4,
    IDX_DIR  = 4'd5
  } gpio_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_async;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_outreg.sv
module gpio_outreg
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     dout_q,
  output logic [W-1:0]     dir_q
);
  logic [W-1:0] dout_d;
  logic [W-1:0] dir_d;

  always_comb begin
    dout_d = dout_q;
    dir_d  = dir_q;
    if (wr_en) begin
      case (wr_idx)
        IDX_DOUT: dout_d = wr_data;
        IDX_SET:  dout_d = dout_q | wr_data;
        IDX_CLR:  dout_d = dout_q & ~wr_data;
        IDX_TGL:  dout_d = dout_q ^ wr_data;
        IDX_DIR:  dir_d  = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
    end
  end

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_SET) |=> dout_q == ($past(dout_q) | $past(wr_data)));
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_CLR) |=> dout_q == ($past(dout_q) & ~$past(wr_data)));
  p_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_TGL) |=> dout_q == ($past(dout_q) ^ $past(wr_data)));
  p_dir_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_DIR) |=> dir_q == $past(wr_data));
  p_din_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_DIN) |=> ($stable(dout_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [W-1:0]     dout,
  input  logic [W-1:0]     dir,
  input  logic [W-1:0]     din_sync,
  output logic [W-1:0]     rdata_q
);
  logic [W-1:0] rdata_d;
  logic [W-1:0] level;

  always_comb begin
    level = (dir & dout) | (~dir & din_sync);
    case (rd_idx)
      IDX_DOUT: rdata_d = dout;
      IDX_DIN:  rdata_d = level;
      IDX_DIR:  rdata_d = dir;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  p_alias_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_idx == IDX_SET || rd_idx == IDX_CLR || rd_idx == IDX_TGL))
    |=> rdata_q == '0);
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/gpio_port32.sv
module gpio_port32
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  logic             rst_meta_q;
  logic             rst_core_n;
  logic             wr_en;
  logic             rd_en;
  logic [NPINS-1:0] din_sync;
  logic [NPINS-1:0] dout_q;
  logic [NPINS-1:0] dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  assign wr_en = bus_sel &  bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .d_async (pad_in),
    .q_sync  (din_sync)
  );

  gpio_outreg #(.W(NPINS)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_idx  (bus_addr),
    .wr_data (bus_wdata),
    .dout_q  (dout_q),
    .dir_q   (dir_q)
  );

  gpio_rdmux #(.W(NPINS)) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_en    (rd_en),
    .rd_idx   (bus_addr),
    .dout     (dout_q),
    .dir      (dir_q),
    .din_sync (din_sync),
    .rdata_q  (bus_rdata)
  );

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;

  p_oe_follows_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && bus_addr == IDX_DIR) |=> pad_oe == $past(bus_wdata));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && bus_addr == IDX_DOUT) |=> pad_out == $past(bus_wdata));
endmodule

// File: tb/sim_gpio_port32.sv
module sim_gpio_port32;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_out = '0;
  logic [31:0] m_dir = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic [31:0] held;

  always #2 clk = ~clk;

  gpio_port32 u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] level(input logic [31:0] pad);
    return (m_dir & m_out) | (~m_dir & pad);
  endfunction

  task automatic apply(input logic [3:0] idx, input logic [31:0] d);
    case (idx)
      4'd0: m_out = d;
      4'd1: m_out = m_out | d;
      4'd2: m_out = m_out & ~d;
      4'd3: m_out = m_out ^ d;
      4'd5: m_dir = d;
      default: ;
    endcase
  endtask

  task automatic drive_wr(input logic [3:0] idx, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = idx; bus_wdata = d;
    apply(idx, d);
  endtask

  task automatic idle();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d, input string tag);
    @(negedge clk); drive_wr(idx, d);
    @(negedge clk); idle();
    check({tag, " pad_out"}, pad_out, m_out);
    check({tag, " pad_oe"}, pad_oe, m_dir);
  endtask

  task automatic drive_rd(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = idx; bus_wdata = '0;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk); drive_rd(idx, exp, tag);
    @(negedge clk); idle();
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard underflow actual %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    pad_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pad_out", pad_out, '0);
    check("R1 pad_oe", pad_oe, '0);
    rd(4'd0, 32'h0, "R1 dout read");
    rd(4'd5, 32'h0, "R1 dir read");

    // R2 full load
    wr(4'd0, 32'hA5A5_0F0F, "R2");
    rd(4'd0, 32'hA5A5_0F0F, "R2 read");

    // R3 set alias, including a zero mask
    wr(4'd1, 32'h0000_00F0, "R3");
    wr(4'd1, 32'h0000_0000, "R3 zero mask");
    // R4 clear alias
    wr(4'd2, 32'h0F0F_000F, "R4");
    // R5 toggle alias
    wr(4'd3, 32'hFFFF_0000, "R5");
    rd(4'd0, m_out, "R5 read");

    // R6 direction
    wr(4'd5, 32'hFFFF_0000, "R6");
    rd(4'd5, 32'hFFFF_0000, "R6 read");

    // R7 mixed level read, then ignored write
    @(negedge clk); pad_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(4'd4, level(32'h1234_5678), "R7 level");
    wr(4'd4, 32'hFFFF_FFFF, "R7 ignored write");
    rd(4'd4, level(32'h1234_5678), "R7 level after write");
    rd(4'd0, m_out, "R7 dout after write");

    // R8 aliases and unmapped read zero
    rd(4'd1, 32'h0, "R8 set alias");
    rd(4'd2, 32'h0, "R8 clr alias");
    rd(4'd3, 32'h0, "R8 tgl alias");
    rd(4'd9, 32'h0, "R8 unmapped 9");
    rd(4'd15, 32'h0, "R8 unmapped 15");

    // R9 synchronizer depth
    @(negedge clk);
    pad_in = 32'h0000_ABCD;
    drive_rd(4'd4, level(32'h1234_5678), "R9 edge k");
    @(negedge clk); drive_rd(4'd4, level(32'h1234_5678), "R9 edge k+1");
    @(negedge clk); drive_rd(4'd4, level(32'h0000_ABCD), "R9 edge k+2");
    @(negedge clk); idle();

    // R10 back-to-back alias writes
    @(negedge clk); drive_wr(4'd1, 32'h0000_1111);
    @(negedge clk); check("R10 after set", pad_out, m_out); drive_wr(4'd2, 32'h0000_0011);
    @(negedge clk); check("R10 after clr", pad_out, m_out); drive_wr(4'd3, 32'h0000_FF00);
    @(negedge clk); check("R10 after tgl", pad_out, m_out); idle();
    rd(4'd0, m_out, "R10 read");

    // R11 read data holds between reads
    held = m_out;
    wr(4'd0, 32'h5555_AAAA, "R11 write");
    repeat (2) @(negedge clk);
    check("R11 hold", bus_rdata, held);
    rd(4'd0, 32'h5555_AAAA, "R11 new read");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule